// File: doc/BRIEF.md
# Floating-Point Compare to Condition Field

This block compares two IEEE-754 values and writes the outcome into one 4-bit field of a 32-bit condition register. It handles three operand shapes: a scalar single-precision value held in the low word of each 64-bit operand, a scalar double-precision value that fills the whole operand, and a pair of single-precision values packed into the two words of each operand. A decoded 11-bit function code selects the shape and the tested relation: greater-than, less-than or equal.

The updated condition register is a combinational function of the operands, the function code, the 3-bit field index and the incoming register value. A start strobe is registered into a valid output one cycle later. The same strobe folds any invalid-operation event into a sticky flag, which stays set until the caller clears it. The caller owns the register file, the status register and the exception path. This block only computes the new condition value and the invalid event.

Top module: `fp_cmp_cond`

## Requirements
- R1: Function codes 0x2CC/0x2CD/0x2CE test greater/less/equal on single precision using bits 31:0 of each operand, with bits 63:32 ignored. Codes 0x2EC/0x2ED/0x2EE run the same tests on double precision using all 64 bits. Codes 0x28C/0x28D/0x28E run them on two single-precision lanes (high lane bits 63:32, low lane bits 31:0).
- R2: A scalar compare writes 4'b0100 into the selected field when the relation holds and 4'b0000 when it does not.
- R3: A vector compare writes {h, l, h|l, h&l}, most significant bit first, where h is the high-lane outcome and l is the low-lane outcome.
- R4: Field index k selects condition bits [(7-k)*4+3 : (7-k)*4], so index 0 is bits 31:28. All other bits of cr_out equal cr_in.
- R5: Non-NaN operands are ordered by sign and magnitude. +0 and -0 are equal. Between two negatives, the larger magnitude is the smaller value. Infinity is greater than every finite value.
- R6: When either operand of a lane is a NaN (exponent all ones, fraction nonzero), the lane is unordered and every relation is false. A quiet NaN (fraction MSB 1) raises no invalid event.
- R7: A signaling NaN (fraction MSB 0) in an operand the selected compare reads raises an invalid event. The event is captured into inv_flag at the clock edge where start is high.
- R8: A function code outside the nine listed codes leaves cr_out equal to cr_in and raises no invalid event.
- R9: cr_out follows the inputs combinationally. done is high exactly in the cycle after a cycle in which start was high.
- R10: inv_flag stays set until inv_clr is sampled high. If inv_clr and a start carrying a new invalid event fall in the same cycle, the flag ends up set.
- R11: After reset, done and inv_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Compare strobe; produces done and captures the invalid event |
| inv_clr | input | 1 | Clears the sticky invalid flag |
| func_code | input | 11 | Decoded function code selecting shape and relation |
| fld_idx | input | 3 | Destination condition field index |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| cr_in | input | 32 | Current condition register value |
| cr_out | output | 32 | Updated condition register value |
| done | output | 1 | Registered valid, one cycle after start |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- Signed zeros of opposite sign. A plain bit-pattern compare would call them unequal.
- Pairs of negative numbers. A raw magnitude compare would invert the greater and less results.
- A single-precision compare with a signaling NaN parked in the unused high word. A decoder that reads the wrong word would raise a spurious invalid event.
- Quiet and signaling NaNs in each shape. These separate the unordered result from the invalid event.
- Vector lanes with differing outcomes. Swapped lanes or a wrong OR/AND bit would show up in the field.
- An all-ones incoming register and an unlisted neighbouring code. These catch clearing of the wrong bits or writes on an unknown code.
- Simultaneous clear and new event. This catches a clear that wins when it should not.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  typedef enum logic [1:0] {
    REL_GT   = 2'd0,
    REL_LT   = 2'd1,
    REL_EQ   = 2'd2,
    REL_NONE = 2'd3
  } rel_e;

  typedef enum logic [1:0] {
    FMT_SGL  = 2'd0,
    FMT_DBL  = 2'd1,
    FMT_VEC  = 2'd2,
    FMT_NONE = 2'd3
  } fmt_e;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
    logic unord;
    logic snan;
  } cmp_res_t;

  function automatic logic rel_hold(cmp_res_t r, rel_e rel);
    case (rel)
      REL_GT:  return r.gt;
      REL_LT:  return r.lt;
      REL_EQ:  return r.eq;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
  import fpcc_pkg::*;
#(
  parameter int FUNC_W = 11
) (
  input  logic [FUNC_W-1:0] func_code,
  output fmt_e              fmt,
  output rel_e              rel
);

  fmt_e fmt_raw;

  always_comb begin
    case (func_code[FUNC_W-1:2])
      9'h0B3:  fmt_raw = FMT_SGL;
      9'h0BB:  fmt_raw = FMT_DBL;
      9'h0A3:  fmt_raw = FMT_VEC;
      default: fmt_raw = FMT_NONE;
    endcase
  end

  always_comb begin
    fmt = fmt_raw;
    rel = REL_NONE;
    if (fmt_raw != FMT_NONE) begin
      case (func_code[1:0])
        2'd0: rel = REL_GT;
        2'd1: rel = REL_LT;
        2'd2: rel = REL_EQ;
        default: begin
          rel = REL_NONE;
          fmt = FMT_NONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/fpcc_lane_cmp.sv
module fpcc_lane_cmp
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output cmp_res_t              res
);

  localparam int MAG_W = EXP_W + FRAC_W;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             a_nan, b_nan, a_snan, b_snan;
  logic             both_zero, mag_lt, mag_eq;

  always_comb begin
    sa        = a[MAG_W];
    sb        = b[MAG_W];
    ma        = a[MAG_W-1:0];
    mb        = b[MAG_W-1:0];
    a_nan     = (&ma[MAG_W-1:FRAC_W]) && (|ma[FRAC_W-1:0]);
    b_nan     = (&mb[MAG_W-1:FRAC_W]) && (|mb[FRAC_W-1:0]);
    a_snan    = a_nan && !ma[FRAC_W-1];
    b_snan    = b_nan && !mb[FRAC_W-1];
    both_zero = !(|ma) && !(|mb);
    mag_lt    = ma < mb;
    mag_eq    = ma == mb;
  end

  always_comb begin
    res       = '0;
    res.unord = a_nan || b_nan;
    res.snan  = a_snan || b_snan;
    if (res.unord) begin
      res.eq = 1'b0;
    end else if (both_zero) begin
      res.eq = 1'b1;
    end else if (sa != sb) begin
      res.gt = !sa;
      res.lt = sa;
    end else if (mag_eq) begin
      res.eq = 1'b1;
    end else if (!sa) begin
      res.gt = !mag_lt;
      res.lt = mag_lt;
    end else begin
      res.gt = mag_lt;
      res.lt = !mag_lt;
    end
  end

endmodule

// File: rtl/fpcc_field_ins.sv
module fpcc_field_ins #(
  parameter int FIELDS  = 8,
  parameter int FIELD_W = 4,
  parameter int IDX_W   = $clog2(FIELDS)
) (
  input  logic [FIELDS*FIELD_W-1:0] cr_in,
  input  logic [IDX_W-1:0]          idx,
  input  logic [FIELD_W-1:0]        nib,
  input  logic                      wr_en,
  output logic [FIELDS*FIELD_W-1:0] cr_out
);

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(FIELDS - 1 - f);
    assign cr_out[f*FIELD_W +: FIELD_W] =
      (wr_en && idx == MY_IDX) ? nib : cr_in[f*FIELD_W +: FIELD_W];
  end

endmodule

// File: rtl/fp_cmp_cond.sv
module fp_cmp_cond
  import fpcc_pkg::*;
#(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int FIELDS   = 8,
  parameter int FUNC_W   = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          inv_clr,
  input  logic [FUNC_W-1:0]             func_code,
  input  logic [$clog2(FIELDS)-1:0]     fld_idx,
  input  logic [DBL_EXP+DBL_FRAC:0]     opa,
  input  logic [DBL_EXP+DBL_FRAC:0]     opb,
  input  logic [FIELDS*4-1:0]           cr_in,
  output logic [FIELDS*4-1:0]           cr_out,
  output logic                          done,
  output logic                          inv_flag
);

  localparam int FIELD_W = 4;
  localparam int SGL_W   = 1 + SGL_EXP + SGL_FRAC;
  localparam int DBL_W   = 1 + DBL_EXP + DBL_FRAC;
  localparam int LANES   = DBL_W / SGL_W;
  localparam int IDX_W   = $clog2(FIELDS);

  fmt_e     fmt;
  rel_e     rel;
  cmp_res_t sgl_res [LANES];
  cmp_res_t dbl_res;

  logic [FIELD_W-1:0] nib;
  logic               wr_en;
  logic               inv_now;
  logic               hi_ok, lo_ok;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       done_q, done_nx;
  logic       inv_q, inv_nx;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  fpcc_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func_code (func_code),
    .fmt       (fmt),
    .rel       (rel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpcc_lane_cmp #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_sgl (
      .a   (opa[g*SGL_W +: SGL_W]),
      .b   (opb[g*SGL_W +: SGL_W]),
      .res (sgl_res[g])
    );
  end

  fpcc_lane_cmp #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_dbl (
    .a   (opa),
    .b   (opb),
    .res (dbl_res)
  );

  always_comb begin
    hi_ok   = rel_hold(sgl_res[LANES-1], rel);
    lo_ok   = rel_hold(sgl_res[0], rel);
    nib     = '0;
    wr_en   = 1'b1;
    inv_now = 1'b0;
    case (fmt)
      FMT_SGL: begin
        nib     = {1'b0, lo_ok, 2'b00};
        inv_now = sgl_res[0].snan;
      end
      FMT_DBL: begin
        nib     = {1'b0, rel_hold(dbl_res, rel), 2'b00};
        inv_now = dbl_res.snan;
      end
      FMT_VEC: begin
        nib     = {hi_ok, lo_ok, hi_ok | lo_ok, hi_ok & lo_ok};
        inv_now = sgl_res[LANES-1].snan | sgl_res[0].snan;
      end
      default: wr_en = 1'b0;
    endcase
  end

  fpcc_field_ins #(.FIELDS(FIELDS), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_ins (
    .cr_in  (cr_in),
    .idx    (fld_idx),
    .nib    (nib),
    .wr_en  (wr_en),
    .cr_out (cr_out)
  );

  always_comb begin
    done_nx = start;
    inv_nx  = (inv_q & ~inv_clr) | (start & inv_now);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      done_q <= done_nx;
      if (start || inv_clr) inv_q <= inv_nx;
    end
  end

  assign done     = done_q;
  assign inv_flag = inv_q;

endmodule

// File: rtl/fpcc_chk.sv
module fpcc_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        start,
  input logic        inv_clr,
  input logic [10:0] func_code,
  input logic [2:0]  fld_idx,
  input logic [31:0] cr_in,
  input logic [31:0] cr_out,
  input logic        done,
  input logic        inv_flag
);

  logic [4:0]  sh;
  logic [31:0] mask;
  logic [3:0]  fld;
  logic        is_scalar, is_vec, is_known;

  always_comb begin
    sh        = 5'((7 - fld_idx) * 4);
    mask      = 32'hF << sh;
    fld       = 4'(cr_out >> sh);
    is_scalar = func_code inside {11'h2CC, 11'h2CD, 11'h2CE, 11'h2EC, 11'h2ED, 11'h2EE};
    is_vec    = func_code inside {11'h28C, 11'h28D, 11'h28E};
    is_known  = is_scalar || is_vec;
  end

  // R9
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> done);

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> !done);

  // R10
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inv_flag && !inv_clr) |=> inv_flag);

  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inv_clr && !start) |=> !inv_flag);

  // R7
  inv_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(inv_flag) |-> $past(start));

  // R4
  other_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cr_out & ~mask) == (cr_in & ~mask));

  // R2
  scalar_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_scalar |-> (fld == 4'b0000 || fld == 4'b0100));

  // R3
  vec_merge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_vec |-> (fld[1] == (fld[3] | fld[2]) && fld[0] == (fld[3] & fld[2])));

  // R8
  unknown_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !is_known |-> cr_out == cr_in);

endmodule

bind fp_cmp_cond fpcc_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .inv_clr    (inv_clr),
  .func_code  (func_code),
  .fld_idx    (fld_idx),
  .cr_in      (cr_in),
  .cr_out     (cr_out),
  .done       (done),
  .inv_flag   (inv_flag)
);

// File: tb/sim_fp_cmp_cond.sv
module sim_fp_cmp_cond;

  typedef struct packed {
    logic [10:0] fc;
    logic [2:0]  ix;
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] ci;
    logic [31:0] co;
    logic        iv;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{11'h2CC, 3'd0, 64'h0000000040000000, 64'h000000003F800000, 32'h12345678, 32'h42345678, 1'b0, 8'd2}, // R2 true
    '{11'h2CD, 3'd1, 64'h0000000040000000, 64'h000000003F800000, 32'h12345678, 32'h10345678, 1'b0, 8'd2}, // R2 false
    '{11'h2CE, 3'd7, 64'h0000000000000000, 64'h0000000080000000, 32'h12345678, 32'h12345674, 1'b0, 8'd5}, // R5 +0==-0
    '{11'h2CC, 3'd2, 64'h00000000BF800000, 64'h00000000C0000000, 32'h12345678, 32'h12445678, 1'b0, 8'd5}, // R5 negatives
    '{11'h2CD, 3'd3, 64'h0000000080000000, 64'h0000000000000000, 32'h12345678, 32'h12305678, 1'b0, 8'd5}, // R5 -0<+0 false
    '{11'h2CE, 3'd4, 64'h000000007FC00000, 64'h000000007FC00000, 32'h12345678, 32'h12340678, 1'b0, 8'd6}, // R6 qNaN
    '{11'h2CD, 3'd5, 64'h000000007F800001, 64'h000000003F800000, 32'h12345678, 32'h12345078, 1'b1, 8'd7}, // R7 sNaN
    '{11'h2CE, 3'd6, 64'h7F8000013F800000, 64'h000000003F800000, 32'h12345678, 32'h12345648, 1'b0, 8'd1}, // R1 high ignored
    '{11'h2EC, 3'd0, 64'h4000000000000000, 64'h3FF0000000000000, 32'h12345678, 32'h42345678, 1'b0, 8'd1}, // R1 double
    '{11'h2ED, 3'd1, 64'hC000000000000000, 64'hBFF0000000000000, 32'h12345678, 32'h14345678, 1'b0, 8'd5}, // R5 double neg
    '{11'h2EE, 3'd2, 64'h3FF0000000000001, 64'h3FF0000000000000, 32'h12345678, 32'h12045678, 1'b0, 8'd1}, // R1 low bit
    '{11'h2EC, 3'd3, 64'h7FF8000000000000, 64'h3FF0000000000000, 32'h12345678, 32'h12305678, 1'b0, 8'd6}, // R6 double qNaN
    '{11'h2EE, 3'd4, 64'h3FF0000000000000, 64'h7FF0000000000001, 32'h12345678, 32'h12340678, 1'b1, 8'd7}, // R7 double sNaN
    '{11'h28C, 3'd0, 64'h400000003F800000, 64'h3F80000040000000, 32'h12345678, 32'hA2345678, 1'b0, 8'd3}, // R3 h only
    '{11'h28D, 3'd1, 64'h3F8000003F800000, 64'h4000000040000000, 32'h12345678, 32'h1F345678, 1'b0, 8'd3}, // R3 both
    '{11'h28E, 3'd7, 64'h3F80000000000000, 64'h4000000080000000, 32'h12345678, 32'h12345676, 1'b0, 8'd3}, // R3 l only
    '{11'h28E, 3'd3, 64'h7FC000003F800000, 64'h7FC000003F800000, 32'h12345678, 32'h12365678, 1'b0, 8'd6}, // R6 vec qNaN
    '{11'h28C, 3'd5, 64'h3F8000007F800001, 64'h0000000000000000, 32'h12345678, 32'h12345A78, 1'b1, 8'd7}, // R7 vec sNaN
    '{11'h2C0, 3'd0, 64'h0000000040000000, 64'h000000003F800000, 32'h12345678, 32'h12345678, 1'b0, 8'd8}, // R8 unknown
    '{11'h2CF, 3'd0, 64'h000000007F800001, 64'h000000003F800000, 32'h12345678, 32'h12345678, 1'b0, 8'd8}, // R8 neighbour
    '{11'h2CC, 3'd6, 64'h000000007F800000, 64'h000000007F7FFFFF, 32'h12345678, 32'h12345648, 1'b0, 8'd5}, // R5 infinity
    '{11'h2CD, 3'd2, 64'h000000003F800000, 64'h000000003F800000, 32'hFFFFFFFF, 32'hFF0FFFFF, 1'b0, 8'd4}  // R4 clear
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        inv_clr;
  logic [10:0] func_code;
  logic [2:0]  fld_idx;
  logic [63:0] opa, opb;
  logic [31:0] cr_in;
  logic [31:0] cr_out;
  logic        done;
  logic        inv_flag;

  int n_chk;
  int n_bad;

  fp_cmp_cond u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .inv_clr   (inv_clr),
    .func_code (func_code),
    .fld_idx   (fld_idx),
    .opa       (opa),
    .opb       (opb),
    .cr_in     (cr_in),
    .cr_out    (cr_out),
    .done      (done),
    .inv_flag  (inv_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic drive(logic [10:0] fc, logic [2:0] ix, logic [63:0] a,
                       logic [63:0] b, logic [31:0] ci);
    func_code = fc;
    fld_idx   = ix;
    opa       = a;
    opb       = b;
    cr_in     = ci;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start = 1'b0;
    inv_clr = 1'b0;
    drive(11'h0, 3'd0, 64'h0, 64'h0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 done after reset", 64'(done), 64'd0);
    check("R11 inv_flag after reset", 64'(inv_flag), 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].fc, TBL[i].ix, TBL[i].a, TBL[i].b, TBL[i].ci);
      inv_clr = 1'b1;
      start   = 1'b0;
      @(negedge clk);
      check($sformatf("R%0d vec %0d cr_out", TBL[i].rq, i), 64'(cr_out), 64'(TBL[i].co));
      start   = 1'b1;
      inv_clr = 1'b0;
      @(negedge clk);
      check($sformatf("R9 vec %0d done", i), 64'(done), 64'd1);
      check($sformatf("R7 vec %0d inv_flag", i), 64'(inv_flag), 64'(TBL[i].iv));
      start = 1'b0;
    end

    // R9 done drops when start is idle
    @(negedge clk);
    check("R9 done idle", 64'(done), 64'd0);

    // R10 sticky: set by an sNaN compare, held across a clean compare
    drive(11'h2CD, 3'd0, 64'h000000007F800001, 64'h000000003F800000, 32'h0);
    start = 1'b1;
    @(negedge clk);
    check("R10 set by sNaN", 64'(inv_flag), 64'd1);
    drive(11'h2CC, 3'd0, 64'h0000000040000000, 64'h000000003F800000, 32'h0);
    @(negedge clk);
    check("R10 held over clean compare", 64'(inv_flag), 64'd1);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 held while idle", 64'(inv_flag), 64'd1);

    // R10 clear and new event in the same cycle: flag stays set
    drive(11'h2EE, 3'd1, 64'h7FF0000000000001, 64'h0, 32'h0);
    start   = 1'b1;
    inv_clr = 1'b1;
    @(negedge clk);
    check("R10 set wins over clear", 64'(inv_flag), 64'd1);
    start = 1'b0;
    @(negedge clk);
    check("R10 clear alone", 64'(inv_flag), 64'd0);
    inv_clr = 1'b0;

    // R7 clean start after clear leaves flag low
    drive(11'h28E, 3'd2, 64'h3F8000003F800000, 64'h3F8000003F800000, 32'h0);
    start = 1'b1;
    @(negedge clk);
    check("R7 no event from ordered compare", 64'(inv_flag), 64'd0);
    check("R3 all-equal vector field", 64'(cr_out), 64'h00F00000);
    start = 1'b0;
    @(negedge clk);

    // R11 reset mid-run clears the flag
    drive(11'h2CC, 3'd0, 64'h000000007F800001, 64'h0, 32'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 inv_flag in reset", 64'(inv_flag), 64'd0);
    check("R11 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule